// File: doc/BRIEF.md
# SPI Register Access Slave

This block is an SPI slave in mode 0 (clock idles low, MOSI sampled on the rising SCLK edge, MISO changed on the falling edge, most significant bit first). Through it a host reaches four read/write control registers and two read-only status registers. A frame is the time chip select is held low. A read frame carries one command byte. A write frame carries a command byte followed by a data byte.

The serial pins are oversampled by the system clock through synchronisers. The transmit register is reloaded only at the end of each byte, from the register addressed by the most recent command, so every reply comes out one frame after the command that requested it. A write lands in its control register only when chip select is released. Status inputs are captured only while chip select is high, so a transfer always sees a frozen picture. Control register 0 holds a watchdog enable in bit 7 and a 4-bit timeout in bits 6:3. Control register 1 holds a 3-bit step mode in bits 7:5 and a 5-bit current setting in bits 4:0. The logic that uses these fields is outside this block.

Top module: `spi_regif`

## Requirements
- R1: Mode 0, MSB first: MOSI is taken on each rising SCLK edge, MISO changes only after a falling SCLK edge, and the first bit of a frame is on MISO before the first rising edge.
- R2: Command byte: bits 7:5 are the opcode (000 read, 100 write) and bits 4:0 the address. Addresses 0 to 3 are control registers, 4 and 5 are status registers, and any other address reads as 00h.
- R3: The transmit register is loaded at the eighth falling SCLK edge of every byte from the register addressed by the latest command, so read data appears in the first byte of the next frame.
- R4: While the data byte of a write frame is shifted in, MISO carries the old contents of the addressed register.
- R5: A write is committed only when chip select rises. A read frame of the same register right after the write still returns the old value, and the new value appears in the frame after that.
- R6: A frame that ends inside a byte, or a write frame without a full data byte, commits nothing, and the next frame starts cleanly on a byte boundary.
- R7: Status register 4 is {watchdog flag, stat_i[6:0]} and status register 5 is stat_i[14:7]. Both are captured only while chip select is high and stay frozen during a frame.
- R8: All control registers reset to 00h, and ctrl_o carries register n in bits 8n+7:8n.
- R9: A write to a status or unmapped address changes no control register.
- R10: The watchdog flag is set by a pulse on wd_trip_i and cleared when a write to register 0 commits with bit 7 at 0. A clear wins over a trip in the same cycle.
- R11: An opcode other than 100 never writes and returns data like a read of its address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| stat_i | input | 15 | Status inputs: bits 6:0 for register 4, bits 14:7 for register 5 |
| wd_trip_i | input | 1 | Pulse that sets the watchdog flag |
| ctrl_o | output | 32 | Control registers 3..0, packed 8 bits each |

## Verification
The bench follows the one-frame lag through a write, then a read-back of the same register, and checks that the old value comes back twice before the new value appears. A design that loaded the transmit register at the start of a byte, or committed during the shift, would return the new value one frame early. Frames cut short inside the command byte or the data byte must leave the registers untouched and must not knock later frames off their byte alignment. Status inputs are changed while chip select is low to show that a design which kept sampling would return the fresh value where the stale one is required. The bench also covers writes to status and unmapped addresses, a non-write opcode carrying a data byte, and clearing the watchdog flag through register 0.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 5;
  localparam int WD_EN_BIT = 7;
  localparam logic [2:0] OP_WRITE = 3'b100;

  typedef logic [BYTE_W-1:0] byte_t;

  // write opcode sits in the top three bits of the command
  function automatic logic cmd_is_write(byte_t cmd);
    return cmd[BYTE_W-1 -: 3] == OP_WRITE;
  endfunction

  function automatic logic [ADDR_W-1:0] cmd_addr(byte_t cmd);
    return cmd[ADDR_W-1:0];
  endfunction
endpackage

// File: rtl/spi_regif_sync.sv
module spi_regif_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_regif_shift.sv
module spi_regif_shift
  import spi_regif_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sclk_s,
  input  logic  cs_n_s,
  input  logic  mosi_s,
  input  byte_t load_data,
  output logic  miso,
  output logic  byte_done,
  output byte_t rx_byte,
  output logic  load_evt,
  output logic  frame_end
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic             sclk_q, cs_n_q;
  logic [CNT_W-1:0] bit_cnt;
  byte_t            rx_sh, tx_sh;
  logic             active, sclk_rise, sclk_fall;

  assign active    = !cs_n_s;
  assign sclk_rise = active && sclk_s && !sclk_q;
  assign sclk_fall = active && !sclk_s && sclk_q;
  assign byte_done = sclk_rise && (bit_cnt == CNT_W'(BYTE_W - 1));
  assign rx_byte   = {rx_sh[BYTE_W-2:0], mosi_s};
  assign load_evt  = sclk_fall && (bit_cnt == CNT_W'(BYTE_W));
  assign frame_end = cs_n_s && !cs_n_q;
  assign miso      = tx_sh[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
    end else begin
      sclk_q <= sclk_s;
      cs_n_q <= cs_n_s;
      if (!active) begin
        bit_cnt <= '0;
      end else if (sclk_rise) begin
        rx_sh   <= rx_byte;
        bit_cnt <= bit_cnt + CNT_W'(1);
      end else if (sclk_fall) begin
        if (load_evt) begin
          tx_sh   <= load_data;
          bit_cnt <= '0;
        end else begin
          tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  a_r1_bit_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(BYTE_W));
  a_r1_miso_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sclk_fall) |-> $stable(miso));
  a_r6_idle_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> bit_cnt == '0);
endmodule

// File: rtl/spi_regif_bank.sv
module spi_regif_bank
  import spi_regif_pkg::*;
#(
  parameter int NUM_CTRL = 4,
  parameter int NUM_STAT = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cs_n_s,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  byte_t                        wr_data,
  output byte_t                        rd_data,
  input  logic [NUM_STAT*BYTE_W-2:0]   stat_i,
  input  logic                         wd_trip_i,
  output logic [NUM_CTRL*BYTE_W-1:0]   ctrl_o
);
  logic [NUM_CTRL-1:0][BYTE_W-1:0] ctrl_q;
  logic [NUM_STAT-1:0][BYTE_W-1:0] snap_q;
  logic [NUM_STAT*BYTE_W-1:0]      stat_full;
  logic                            wd_flag, wd_clr;

  assign stat_full = {stat_i[NUM_STAT*BYTE_W-2:BYTE_W-1], wd_flag, stat_i[BYTE_W-2:0]};
  assign wd_clr    = wr_en && (addr == '0) && !wr_data[WD_EN_BIT];
  assign ctrl_o    = ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      snap_q  <= '0;
      wd_flag <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_CTRL; i++)
        if (wr_en && addr == ADDR_W'(i)) ctrl_q[i] <= wr_data;
      if (cs_n_s) snap_q <= stat_full;
      if (wd_clr)         wd_flag <= 1'b0;
      else if (wd_trip_i) wd_flag <= 1'b1;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_CTRL; i++)
      if (addr == ADDR_W'(i)) rd_data = ctrl_q[i];
    for (int s = 0; s < NUM_STAT; s++)
      if (addr == ADDR_W'(NUM_CTRL + s)) rd_data = snap_q[s];
  end

  a_r7_snapshot_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cs_n_s) |-> $stable(snap_q));
  a_r5_commit_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cs_n_s) |-> $stable(ctrl_q));
  a_r9_protected_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr >= ADDR_W'(NUM_CTRL)) |=> $stable(ctrl_q));
  a_r10_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == '0 && !wr_data[WD_EN_BIT]) |=> !wd_flag);
endmodule

// File: rtl/spi_regif.sv
module spi_regif
  import spi_regif_pkg::*;
#(
  parameter int NUM_CTRL    = 4,
  parameter int NUM_STAT    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sclk,
  input  logic                       cs_n,
  input  logic                       mosi,
  output logic                       miso,
  input  logic [NUM_STAT*BYTE_W-2:0] stat_i,
  input  logic                       wd_trip_i,
  output logic [NUM_CTRL*BYTE_W-1:0] ctrl_o
);
  localparam int         NPINS    = 3;
  localparam logic [2:0] SYNC_RST = 3'b100;  // {cs_n, sclk, mosi}

  logic [NPINS-1:0] pin_raw, pin_s;
  logic  sclk_s, cs_n_s, mosi_s;
  logic  byte_done, load_evt, frame_end, wr_en, wr_pend;
  byte_t rx_byte, rd_data, cmd_q, wdata_q;
  logic [1:0] byte_idx;

  assign pin_raw = {cs_n, sclk, mosi};
  for (genvar g = 0; g < NPINS; g++) begin : g_sync
    spi_regif_sync #(.STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST[g])) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_raw[g]), .q(pin_s[g]));
  end
  assign {cs_n_s, sclk_s, mosi_s} = pin_s;

  spi_regif_shift u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .cs_n_s(cs_n_s), .mosi_s(mosi_s),
    .load_data(rd_data), .miso(miso), .byte_done(byte_done), .rx_byte(rx_byte),
    .load_evt(load_evt), .frame_end(frame_end));

  // frame sequencing: byte 0 is the command, byte 1 the write data
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_idx <= '0;
      cmd_q    <= '0;
      wdata_q  <= '0;
      wr_pend  <= 1'b0;
    end else if (cs_n_s) begin
      byte_idx <= '0;
      wr_pend  <= 1'b0;
    end else if (byte_done) begin
      if (byte_idx == 2'd0) begin
        cmd_q <= rx_byte;
      end else if (byte_idx == 2'd1 && cmd_is_write(cmd_q)) begin
        wdata_q <= rx_byte;
        wr_pend <= 1'b1;
      end
      if (byte_idx != 2'd2) byte_idx <= byte_idx + 2'd1;
    end
  end

  assign wr_en = frame_end && wr_pend;

  spi_regif_bank #(.NUM_CTRL(NUM_CTRL), .NUM_STAT(NUM_STAT)) u_bank (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .wr_en(wr_en),
    .addr(cmd_addr(cmd_q)), .wr_data(wdata_q), .rd_data(rd_data),
    .stat_i(stat_i), .wd_trip_i(wd_trip_i), .ctrl_o(ctrl_o));

  a_r6_commit_full_frame: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> byte_idx == 2'd2);
  a_r11_commit_write_op: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> cmd_is_write(cmd_q));
  a_r3_load_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> byte_idx != 2'd0);
endmodule

// File: tb/tb_spi_regif.sv
module tb_spi_regif;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        mosi = 1'b0;
  logic        miso;
  logic [14:0] stat_i = {8'hA5, 7'h3C};
  logic        wd_trip_i = 1'b0;
  logic [31:0] ctrl_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  spi_regif dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .stat_i(stat_i), .wd_trip_i(wd_trip_i), .ctrl_o(ctrl_o));

  // {two_bytes, chk0, chk1, cmd, data, exp0, exp1}
  localparam int NV = 15;
  localparam logic [34:0] VEC [NV] = '{
    {3'b101, 8'h82, 8'h5A, 8'h00, 8'h00},  // write r2; old r2 during data (R4)
    {3'b010, 8'h02, 8'h00, 8'h00, 8'h00},  // read r2: still old (R5)
    {3'b010, 8'h01, 8'h00, 8'h5A, 8'h00},  // r2 new one frame later (R3)
    {3'b111, 8'h81, 8'hE7, 8'h00, 8'h00},  // write r1, old 00 (R4)
    {3'b010, 8'h04, 8'h00, 8'h00, 8'h00},  // old r1 again (R5)
    {3'b010, 8'h05, 8'h00, 8'h3C, 8'h00},  // status 4 (R7)
    {3'b111, 8'h85, 8'hFF, 8'hA5, 8'hA5},  // write status 5 (R9)
    {3'b010, 8'h1F, 8'h00, 8'hA5, 8'h00},  // status 5 unchanged (R9)
    {3'b010, 8'h01, 8'h00, 8'h00, 8'h00},  // unmapped reads 00 (R2)
    {3'b111, 8'h21, 8'h00, 8'hE7, 8'hE7},  // opcode 001 with data (R11)
    {3'b010, 8'h01, 8'h00, 8'hE7, 8'h00},  // r1 untouched (R11)
    {3'b010, 8'h03, 8'h00, 8'hE7, 8'h00},  // r1 read back (R11)
    {3'b111, 8'h80, 8'hB8, 8'h00, 8'h00},  // write r0 (R4)
    {3'b010, 8'h00, 8'h00, 8'h00, 8'h00},  // old r0 (R5)
    {3'b010, 8'h00, 8'h00, 8'hB8, 8'h00}   // new r0, MSB first (R1)
  };

  function automatic string vec_req(int i);
    case (i)
      0, 3, 12: return "R4";
      1, 4, 13: return "R5";
      2:        return "R3";
      5:        return "R7";
      6, 7:     return "R9";
      8:        return "R2";
      9, 10, 11: return "R11";
      default:  return "R1";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic xfer_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i >= 8 - nbits; i--) begin
      mosi = tx[i];
      #40;
      rx[i] = miso;
      sclk = 1'b1;
      #40;
      sclk = 1'b0;
    end
  endtask

  task automatic frame(input logic two, input logic [7:0] b0, input logic [7:0] b1,
                       output logic [7:0] r0, output logic [7:0] r1);
    cs_n = 1'b0;
    #80;
    xfer_bits(b0, 8, r0);
    r1 = '0;
    if (two) xfer_bits(b1, 8, r1);
    #80;
    cs_n = 1'b1;
    #120;
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] r0, r1;
    #51;
    check("R8 reset", ctrl_o, 32'h0);
    #50;
    rst_n = 1'b1;
    #200;
    check("R8 after reset", ctrl_o, 32'h0);

    for (int v = 0; v < NV; v++) begin
      frame(VEC[v][34], VEC[v][31:24], VEC[v][23:16], r0, r1);
      if (VEC[v][33]) check(vec_req(v), {24'h0, r0}, {24'h0, VEC[v][15:8]});
      if (VEC[v][32]) check(vec_req(v), {24'h0, r1}, {24'h0, VEC[v][7:0]});
    end
    check("R1 R8 ctrl_o packing", ctrl_o, 32'h005AE7B8);

    // R6: frame ends inside the data byte
    cs_n = 1'b0; #80;
    xfer_bits(8'h83, 8, r0);
    xfer_bits(8'hC3, 4, r1);
    #80; cs_n = 1'b1; #120;
    check("R6 partial data byte", ctrl_o, 32'h005AE7B8);
    // R6: write command with no data byte
    frame(1'b0, 8'h83, 8'h00, r0, r1);
    check("R6 command only", ctrl_o, 32'h005AE7B8);
    // R6: frame ends inside the command byte
    cs_n = 1'b0; #80;
    xfer_bits(8'h83, 5, r0);
    #80; cs_n = 1'b1; #120;
    frame(1'b0, 8'h02, 8'h00, r0, r1);
    frame(1'b0, 8'h02, 8'h00, r0, r1);
    check("R6 realigned read", {24'h0, r0}, 32'h5A);

    // R7: status changes while chip select is low
    stat_i = {8'hA5, 7'h11};
    #200;
    cs_n = 1'b0; #80;
    stat_i = {8'hA5, 7'h55};
    xfer_bits(8'h04, 8, r0);
    #80; cs_n = 1'b1; #120;
    frame(1'b0, 8'h04, 8'h00, r0, r1);
    check("R7 stale snapshot", {24'h0, r0}, 32'h11);
    frame(1'b0, 8'h04, 8'h00, r0, r1);
    check("R7 fresh snapshot", {24'h0, r0}, 32'h55);

    // R10: watchdog flag set, then cleared through register 0
    @(posedge clk); #1 wd_trip_i = 1'b1;
    @(posedge clk); #1 wd_trip_i = 1'b0;
    #40;
    frame(1'b0, 8'h04, 8'h00, r0, r1);
    check("R10 flag before reload", {24'h0, r0}, 32'h55);
    frame(1'b1, 8'h80, 8'h38, r0, r1);
    check("R10 flag set", {24'h0, r0}, 32'hD5);
    check("R4 old r0", {24'h0, r1}, 32'hB8);
    frame(1'b0, 8'h04, 8'h00, r0, r1);
    check("R5 old r0 again", {24'h0, r0}, 32'hB8);
    frame(1'b0, 8'h04, 8'h00, r0, r1);
    check("R10 flag cleared", {24'h0, r0}, 32'h55);
    check("R10 ctrl reg0", {24'h0, ctrl_o[7:0]}, 32'h38);

    summary();
    $finish;
  end
endmodule